// File: doc/BRIEF.md
# Clock Gating Controller with Idle Wake

This block decides which clocks of a subsystem run. It drives gate enables and glitch-free gated clocks for one processor clock, one DDR system clock and a parameterised group of peripheral clocks (up to 32). Software controls it through a small register bus. For each clock group there is a turn-on register and a turn-off register. A 1 in a written bit acts on the matching clock and a 0 bit leaves that clock alone. A status register reads back which clocks are actually running.

Peripheral gates switch at the bus write, with no handshake. The processor clock works differently, so that the processor can enter an idle state. A stop request is held pending until the processor reports that its current instruction is complete, and only then does the gate close. Any fast or normal interrupt reopens the processor gate without software. An interrupt that arrives while a stop is pending cancels the stop. The DDR gate is forced off whenever the master clock divider setting is 00.

Register map (word address on `bus_addr`): 0 system turn-on, 1 system turn-off, 2 system status, 4 peripheral turn-on, 5 peripheral turn-off, 6 peripheral status. In the system registers, bit 0 is the processor clock and bit 1 is the DDR clock. System status bit 2 reads back a pending processor stop. Peripheral register bit i controls peripheral clock i.

Top module: `clkgate_ctrl`

## Requirements
- R1: After reset, `cpu_en` is 1, `ddr_en` is 0 and every bit of `per_en` is 0. System status (address 2) reads 1 and peripheral status (address 6) reads 0.
- R2: A write to address 4 sets every peripheral enable whose data bit is 1, starting with the clock edge that takes the write. Enables whose data bit is 0 keep their value.
- R3: A write to address 5 clears every peripheral enable whose data bit is 1. The enable is low right after the edge that takes the write, with no deferral.
- R4: Writes to the status addresses (2, 6) change no clock. A read of an unmapped address returns 0. Address 6 reads the peripheral enables in bits NPER-1:0.
- R5: A write to address 1 with bit 0 set makes a processor stop pending, shown in system status bit 2. The stop does not change `cpu_en`. `cpu_en` stays 1 while `instr_done` is 0. It falls at the first edge where the stop is pending and `instr_done` is 1.
- R6: A high level on `irq_norm` or `irq_fast` at a clock edge sets `cpu_en` to 1 at that edge and cancels any pending stop.
- R7: A write to address 0 with bit 0 set reopens a stopped processor clock and cancels a pending stop.
- R8: The DDR enable resets to 0. It is set by address 0 bit 1 and cleared by address 1 bit 1. System status bit 1 shows whether the DDR clock is running.
- R9: While `mck_div` is 2'b00, `ddr_en` and system status bit 1 are 0, whatever the DDR enable request. The request itself is kept.
- R10: Each gated clock output equals its source clock ANDed with its enable as captured on the falling edge. A disabled gate therefore stays low through the whole high phase of its clock.
- R11: Processor idle entry and exit leave the peripheral enables unchanged. Peripheral enables change only on peripheral turn-on or turn-off writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; source for the processor and peripheral gates |
| rst_n | input | 1 | Asynchronous active-low reset |
| ddr_clk_in | input | 1 | DDR system clock source for the DDR gate |
| mck_div | input | 2 | Master clock divider setting; 00 forces the DDR gate off |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| irq_norm | input | 1 | Enabled normal interrupt request (level) |
| irq_fast | input | 1 | Enabled fast interrupt request (level) |
| instr_done | input | 1 | Processor current instruction complete (level, sampled each cycle) |
| cpu_en | output | 1 | Processor clock gate enable |
| ddr_en | output | 1 | Effective DDR clock gate enable |
| per_en | output | NPER | Peripheral clock gate enables |
| cpu_clk_out | output | 1 | Gated processor clock |
| ddr_clk_out | output | 1 | Gated DDR system clock |
| per_clk_out | output | NPER | Gated peripheral clocks |

## Verification
The hardest case to reach is a processor stop that is pending but then cancelled. It needs a turn-off write while `instr_done` is held low, followed by an interrupt. The interrupt must land before `instr_done` rises. After that, the bench shows that raising `instr_done` no longer closes the gate. The stimulus reaches this by holding `instr_done` low across the write, reading system status to confirm the pending bit, and then pulsing `irq_fast` for one cycle. It raises `instr_done` only on the following cycle and then watches `cpu_en` for several cycles.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    A_SYS_ON   = 4'h0,
    A_SYS_OFF  = 4'h1,
    A_SYS_STAT = 4'h2,
    A_PER_ON   = 4'h4,
    A_PER_OFF  = 4'h5,
    A_PER_STAT = 4'h6
  } reg_addr_e;

  localparam int SYS_CPU_BIT  = 0;
  localparam int SYS_DDR_BIT  = 1;
  localparam int SYS_PEND_BIT = 2;

  // next state of a set/clear bank: turn-off wins over turn-on
  function automatic logic [REG_DW-1:0] setclr_next(input logic [REG_DW-1:0] cur,
                                                    input logic [REG_DW-1:0] on,
                                                    input logic [REG_DW-1:0] off);
    return (cur | on) & ~off;
  endfunction

  // DDR gate is usable only when the master divider is not 00
  function automatic logic div_allows_ddr(input logic [1:0] div);
    return div != 2'b00;
  endfunction
endpackage

// File: rtl/cg_glitchfree_cell.sv
`timescale 1ns/1ps
module cg_glitchfree_cell #(
  parameter bit RST_EN = 1'b0
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic en,
  output logic clk_out
);
  logic en_q;

  // enable captured while the clock is low, so the AND never chops a high phase
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) en_q <= RST_EN;
    else        en_q <= en;
  end

  assign clk_out = clk_in & en_q;
endmodule

// File: rtl/cg_setclr_bank.sv
`timescale 1ns/1ps
module cg_setclr_bank
  import clkgate_pkg::*;
#(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits,
  output logic [W-1:0] state
);
  logic [REG_DW-1:0] on32, off32, cur32, nxt32;

  always_comb begin
    on32  = '0;
    off32 = '0;
    cur32 = '0;
    cur32[W-1:0] = state;
    if (set_stb) on32[W-1:0]  = bits;
    if (clr_stb) off32[W-1:0] = bits;
    nxt32 = setclr_next(cur32, on32, off32);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RST_VAL;
    else        state <= nxt32[W-1:0];
  end
endmodule

// File: rtl/cg_cpu_idle.sv
`timescale 1ns/1ps
module cg_cpu_idle (
  input  logic clk,
  input  logic rst_n,
  input  logic off_req,
  input  logic on_req,
  input  logic wake,
  input  logic instr_done,
  output logic run,
  output logic pend,
  output logic close_evt
);
  assign close_evt = pend & instr_done & ~wake & ~off_req & ~on_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b1;
      pend <= 1'b0;
    end else if (wake) begin
      run  <= 1'b1;
      pend <= 1'b0;
    end else if (off_req) begin
      pend <= run;
    end else if (on_req) begin
      run  <= 1'b1;
      pend <= 1'b0;
    end else if (close_evt) begin
      run  <= 1'b0;
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/cg_regif.sv
`timescale 1ns/1ps
module cg_regif
  import clkgate_pkg::*;
#(
  parameter int NPER = 32
) (
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [2:0]        sys_stat,
  input  logic [NPER-1:0]   per_stat,
  output logic              wr_sys_on,
  output logic              wr_sys_off,
  output logic              wr_per_on,
  output logic              wr_per_off,
  output logic [REG_DW-1:0] rdata
);
  assign wr_sys_on  = bus_wr && (bus_addr == A_SYS_ON);
  assign wr_sys_off = bus_wr && (bus_addr == A_SYS_OFF);
  assign wr_per_on  = bus_wr && (bus_addr == A_PER_ON);
  assign wr_per_off = bus_wr && (bus_addr == A_PER_OFF);

  always_comb begin
    rdata = '0;
    case (bus_addr)
      A_SYS_STAT: rdata[2:0]      = sys_stat;
      A_PER_STAT: rdata[NPER-1:0] = per_stat;
      default:    rdata           = '0;
    endcase
  end
endmodule

// File: rtl/clkgate_ctrl.sv
`timescale 1ns/1ps
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int NPER = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ddr_clk_in,
  input  logic [1:0]        mck_div,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [REG_DW-1:0] bus_wdata,
  output logic [REG_DW-1:0] bus_rdata,
  input  logic              irq_norm,
  input  logic              irq_fast,
  input  logic              instr_done,
  output logic              cpu_en,
  output logic              ddr_en,
  output logic [NPER-1:0]   per_en,
  output logic              cpu_clk_out,
  output logic              ddr_clk_out,
  output logic [NPER-1:0]   per_clk_out
);
  localparam logic [NPER-1:0] PER_RST = '0;

  logic wr_sys_on, wr_sys_off, wr_per_on, wr_per_off;
  logic cpu_wake, cpu_stop_pend, cpu_close;
  logic ddr_req;
  logic [2:0] sys_stat;

  cg_regif #(.NPER(NPER)) u_regif (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .sys_stat  (sys_stat),
    .per_stat  (per_en),
    .wr_sys_on (wr_sys_on),
    .wr_sys_off(wr_sys_off),
    .wr_per_on (wr_per_on),
    .wr_per_off(wr_per_off),
    .rdata     (bus_rdata)
  );

  assign cpu_wake = irq_norm | irq_fast;

  cg_cpu_idle u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .off_req   (wr_sys_off & bus_wdata[SYS_CPU_BIT]),
    .on_req    (wr_sys_on & bus_wdata[SYS_CPU_BIT]),
    .wake      (cpu_wake),
    .instr_done(instr_done),
    .run       (cpu_en),
    .pend      (cpu_stop_pend),
    .close_evt (cpu_close)
  );

  cg_setclr_bank #(.W(1), .RST_VAL(1'b0)) u_ddr_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_stb(wr_sys_on),
    .clr_stb(wr_sys_off),
    .bits   (bus_wdata[SYS_DDR_BIT]),
    .state  (ddr_req)
  );

  cg_setclr_bank #(.W(NPER), .RST_VAL(PER_RST)) u_per_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_stb(wr_per_on),
    .clr_stb(wr_per_off),
    .bits   (bus_wdata[NPER-1:0]),
    .state  (per_en)
  );

  assign ddr_en   = ddr_req & div_allows_ddr(mck_div);
  assign sys_stat = {cpu_stop_pend, ddr_en, cpu_en};

  cg_glitchfree_cell #(.RST_EN(1'b1)) u_cpu_gate (
    .clk_in(clk), .rst_n(rst_n), .en(cpu_en), .clk_out(cpu_clk_out)
  );

  cg_glitchfree_cell #(.RST_EN(1'b0)) u_ddr_gate (
    .clk_in(ddr_clk_in), .rst_n(rst_n), .en(ddr_en), .clk_out(ddr_clk_out)
  );

  for (genvar i = 0; i < NPER; i++) begin : g_per_gate
    cg_glitchfree_cell #(.RST_EN(1'b0)) u_gate (
      .clk_in(clk), .rst_n(rst_n), .en(per_en[i]), .clk_out(per_clk_out[i])
    );
  end
endmodule

// File: rtl/clkgate_ctrl_chk.sv
`timescale 1ns/1ps
module clkgate_ctrl_chk
  import clkgate_pkg::*;
#(
  parameter int NPER = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mck_div,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [REG_DW-1:0] bus_wdata,
  input logic [REG_DW-1:0] bus_rdata,
  input logic              irq_norm,
  input logic              irq_fast,
  input logic              instr_done,
  input logic              cpu_en,
  input logic [NPER-1:0]   per_en,
  input logic              cpu_close
);
  // R2
  per_on_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PER_ON) |=>
      ((per_en & $past(bus_wdata[NPER-1:0])) == $past(bus_wdata[NPER-1:0])));

  // R3
  per_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_PER_OFF) |=> ((per_en & $past(bus_wdata[NPER-1:0])) == '0));

  // R11
  per_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == A_PER_ON || bus_addr == A_PER_OFF)) |=> $stable(per_en));

  // R5
  cpu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && !instr_done) |=> cpu_en);

  // R5
  cpu_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_close |=> !cpu_en);

  // R6
  cpu_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_norm || irq_fast) |=> cpu_en);

  // R9
  ddr_forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mck_div == 2'b00 && bus_addr == A_SYS_STAT) |-> !bus_rdata[SYS_DDR_BIT]);
endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(.NPER(NPER)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mck_div   (mck_div),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_norm  (irq_norm),
  .irq_fast  (irq_fast),
  .instr_done(instr_done),
  .cpu_en    (cpu_en),
  .per_en    (per_en),
  .cpu_close (cpu_close)
);

// File: tb/sim_clkgate_ctrl.sv
`timescale 1ns/1ps
module sim_clkgate_ctrl;
  localparam int NPER = 32;

  logic clk = 1'b0;
  logic ddr_clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mck_div = 2'b01;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq_norm = 1'b0, irq_fast = 1'b0, instr_done = 1'b0;
  logic cpu_en, ddr_en, cpu_clk_out, ddr_clk_out;
  logic [NPER-1:0] per_en, per_clk_out;

  always #2 clk = ~clk;
  always #1 ddr_clk = ~ddr_clk;

  clkgate_ctrl #(.NPER(NPER)) u0 (
    .clk(clk), .rst_n(rst_n), .ddr_clk_in(ddr_clk), .mck_div(mck_div),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_norm(irq_norm), .irq_fast(irq_fast), .instr_done(instr_done),
    .cpu_en(cpu_en), .ddr_en(ddr_en), .per_en(per_en),
    .cpu_clk_out(cpu_clk_out), .ddr_clk_out(ddr_clk_out), .per_clk_out(per_clk_out)
  );

  // kinds: 0 cpu_en, 1 ddr_en, 2 per_en, 3 bus_rdata
  typedef struct {
    string       req;
    int          kind;
    logic [31:0] exp;
  } exp_t;
  exp_t sb_q[$];

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic [31:0] m_per = '0;
  logic        m_ddr_req = 1'b0;
  logic        m_cpu = 1'b1;

  function automatic logic [31:0] model_bits(input logic [31:0] cur, input logic [31:0] on,
                                             input logic [31:0] off);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (off[i])      r[i] = 1'b0;
      else if (on[i])  r[i] = 1'b1;
      else             r[i] = cur[i];
    end
    return r;
  endfunction

  task automatic push(input string req, input int kind, input logic [31:0] exp);
    exp_t e;
    e.req = req; e.kind = kind; e.exp = exp;
    sb_q.push_back(e);
  endtask

  // monitor: compares queued items 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        logic [31:0] act;
        e = sb_q.pop_front();
        case (e.kind)
          0:       act = {31'b0, cpu_en};
          1:       act = {31'b0, ddr_en};
          2:       act = per_en;
          default: act = bus_rdata;
        endcase
        checks++;
        if (act !== e.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", e.req, e.kind, act, e.exp);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_expect(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    push(req, 3, exp);
    step();
  endtask

  task automatic expect_all(input string req);
    push(req, 0, {31'b0, m_cpu});
    push(req, 1, {31'b0, m_ddr_req & (mck_div != 2'b00)});
    push(req, 2, m_per);
    step();
  endtask

  // gated clock sampled in the high phase
  task automatic gclk_chk(input string req, input logic act_sel, input int idx, input logic exp);
    logic act;
    @(posedge clk);
    #0.5;
    act = act_sel ? per_clk_out[idx] : cpu_clk_out;
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s gated clock actual=%b expected=%b", req, act, exp);
    end
    @(negedge clk);
  endtask

  function automatic logic [31:0] sys_stat_exp(input logic pend);
    return {29'b0, pend, m_ddr_req & (mck_div != 2'b00), m_cpu};
  endfunction

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    expect_all("R1");
    rd_expect("R1", 4'h2, 32'h1);
    rd_expect("R1", 4'h6, 32'h0);

    // R2 turn-on with mixed patterns
    wr(4'h4, 32'h0000_00A5); m_per = model_bits(m_per, 32'h0000_00A5, '0);
    expect_all("R2");
    wr(4'h4, 32'h8000_0100); m_per = model_bits(m_per, 32'h8000_0100, '0);
    expect_all("R2");

    // R3 immediate turn-off
    wr(4'h5, 32'h8000_0005); m_per = model_bits(m_per, '0, 32'h8000_0005);
    expect_all("R3");

    // R4 status writes ignored, unmapped read zero
    wr(4'h6, 32'hFFFF_FFFF);
    expect_all("R4");
    wr(4'h2, 32'h0000_0003);
    expect_all("R4");
    rd_expect("R4", 4'h6, m_per);
    rd_expect("R4", 4'h3, 32'h0);
    rd_expect("R4", 4'hF, 32'h0);

    // R8 DDR set/clear/status
    wr(4'h0, 32'h2); m_ddr_req = 1'b1;
    expect_all("R8");
    rd_expect("R8", 4'h2, sys_stat_exp(1'b0));
    wr(4'h1, 32'h2); m_ddr_req = 1'b0;
    expect_all("R8");

    // R9 divider 00 forces DDR gate off
    mck_div = 2'b00;
    wr(4'h0, 32'h2); m_ddr_req = 1'b1;
    expect_all("R9");
    rd_expect("R9", 4'h2, sys_stat_exp(1'b0));
    mck_div = 2'b11;
    step();
    expect_all("R9");
    wr(4'h1, 32'h2); m_ddr_req = 1'b0;

    // R5 stop waits for instruction completion
    instr_done = 1'b0;
    wr(4'h1, 32'h1);
    expect_all("R5");
    rd_expect("R5", 4'h2, sys_stat_exp(1'b1));
    step(); step();
    expect_all("R5");
    instr_done = 1'b1;
    step(); m_cpu = 1'b0;
    expect_all("R5");
    rd_expect("R5", 4'h2, sys_stat_exp(1'b0));

    // R10 gated clocks; R11 peripherals keep running during idle
    gclk_chk("R10", 1'b0, 0, 1'b0);
    gclk_chk("R11", 1'b1, 7, 1'b1);
    gclk_chk("R10", 1'b1, 0, 1'b0);

    // R6 normal interrupt wakes
    irq_norm = 1'b1;
    step(); irq_norm = 1'b0; m_cpu = 1'b1;
    expect_all("R6");
    gclk_chk("R10", 1'b0, 0, 1'b1);

    // R6 fast interrupt wakes after a stop with done already high
    wr(4'h1, 32'h1);
    expect_all("R5");
    m_cpu = 1'b0;
    expect_all("R5");
    irq_fast = 1'b1;
    step(); irq_fast = 1'b0; m_cpu = 1'b1;
    expect_all("R6");

    // R6 interrupt cancels a pending stop
    instr_done = 1'b0;
    wr(4'h1, 32'h1);
    rd_expect("R6", 4'h2, sys_stat_exp(1'b1));
    irq_fast = 1'b1;
    step(); irq_fast = 1'b0; instr_done = 1'b1;
    step(); step();
    expect_all("R6");
    rd_expect("R6", 4'h2, sys_stat_exp(1'b0));

    // R7 software turn-on reopens the processor clock
    wr(4'h1, 32'h1);
    step(); m_cpu = 1'b0;
    expect_all("R7");
    wr(4'h0, 32'h1); m_cpu = 1'b1;
    expect_all("R7");

    // R3 clear everything
    wr(4'h5, 32'hFFFF_FFFF); m_per = '0;
    expect_all("R3");

    step(); step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule